// File: doc/BRIEF.md
# Self-Calibration Mode Sequencer

This block is the control state machine of a self-calibrating sensor signal chain. It moves the chain through seven named states: ST_RESET, ST_POWERUP, ST_OFS_INIT, ST_CAL_WAIT, ST_CAL_RECENTER, ST_RUN and ST_RUN_RECENTER. While the supply is low the chain is held in reset with its output forced to the high level. When the supply recovers, a fixed power-up settle is followed by an initial offset cancellation. That cancellation is bounded by a timeout counter sized for the power-up time budget.

Calibration follows. Each measured peak-to-peak amplitude may raise or lower a gain index, and every gain step is followed by an offset re-centering handshake before another decision is taken. Calibration closes on a set count of output rising edges. After that the block runs with a gain that can only fall. It drives a gain code, an offset re-centering request, an offset-loop enable, a tracker enable, a forced output level, a two-bit mode code and a duty-valid flag.

The transitions are as follows. Undervoltage moves any state to ST_RESET. ST_RESET goes to ST_POWERUP once the supply is good. ST_POWERUP goes to ST_OFS_INIT when the settle count ends. ST_OFS_INIT goes to ST_CAL_WAIT when the offset settles or the timeout expires. ST_CAL_WAIT goes to ST_CAL_RECENTER on a gain step, or to ST_RUN on the final calibration edge. ST_CAL_RECENTER returns to ST_CAL_WAIT when the offset settles. ST_RUN goes to ST_RUN_RECENTER on a gain reduction, and ST_RUN_RECENTER returns to ST_RUN when the offset settles.

Top module: `cal_sequencer`

## Requirements
- R1: One clock edge after uv_flag is sampled high, from any state, the block is in reset with mode 0, out_force_hi 1, trk_en 0, ofs_en 0, ofs_req 0, duty_ok 0 and gain_code equal to GAIN_INIT. It stays there while uv_flag remains high.
- R2: After uv_flag falls, the block spends PWR_CYC edges in power-up (mode 0) and then enters the initial offset state (mode 1, ofs_req 1, ofs_en 1, out_force_hi 1, trk_en 0). It stays there until ofs_done is sampled high, and calibration (mode 2) begins on that edge.
- R3: If ofs_done never arrives, the block leaves the initial offset state for calibration on the PO_LIMIT-th edge after power-up began.
- R4: In calibration with no re-centering pending, a valid amplitude below AMP_LO raises gain_code by 1 and one above AMP_HI lowers it by 1. An amplitude from AMP_LO to AMP_HI inclusive leaves it unchanged.
- R5: Every gain step raises ofs_req on the same edge. Further amplitudes are ignored until ofs_done is sampled, and ofs_req falls on that edge.
- R6: In calibration, trk_en is 1, out_force_hi is 0 and duty_ok is 0.
- R7: Counted from the start of calibration, the CAL_EDGES-th out_rise pulse moves the block to running (mode 3) on that edge. It takes priority over an amplitude sampled in the same cycle.
- R8: In running mode, an amplitude above AMP_HI lowers gain_code by 1 with a re-centering handshake, and an amplitude below AMP_LO never raises it.
- R9: ofs_en is 1 in modes 1, 2 and 3, and duty_ok is 1 exactly in mode 3.
- R10: gain_code saturates at 0 and at its maximum. A step that would pass either end changes nothing and raises no re-centering request.
- R11: An undervoltage event restarts the full sequence, including the power-up timer and the calibration edge count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_flag | input | 1 | Supply below lockout level |
| ofs_done | input | 1 | Offset loop reports settled |
| amp_valid | input | 1 | Pulse: amp_pp holds a new per-cycle amplitude |
| amp_pp | input | AMP_W | Measured peak-to-peak amplitude |
| out_rise | input | 1 | Pulse on each output rising edge |
| gain_code | output | GAIN_W | Gain index, 0 is lowest gain |
| ofs_req | output | 1 | Offset re-centering request |
| ofs_en | output | 1 | Offset correction loop enable |
| trk_en | output | 1 | Peak tracker enable |
| out_force_hi | output | 1 | Force output to its power-on high level |
| mode | output | 2 | 0 reset/power-up, 1 initial offset, 2 calibration, 3 running |
| duty_ok | output | 1 | Output duty cycle within specification |

## Verification
Every state change and gain step is registered, so each result is due on the first clock edge after the stimulus that causes it. The power-up settle and the timeout are exceptions: they land PWR_CYC and PO_LIMIT edges after uv_flag falls. The bench applies each stimulus just after a rising edge and then queues the outputs expected after the next edge. A monitor compares them at the following falling edge, so no comparison sits on the edge where the values move. The timeout and the settle length are checked cycle by cycle, with one queued expectation per edge.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

    typedef enum logic [2:0] {
        ST_RESET,
        ST_POWERUP,
        ST_OFS_INIT,
        ST_CAL_WAIT,
        ST_CAL_RECENTER,
        ST_RUN,
        ST_RUN_RECENTER
    } seq_state_t;

    typedef enum logic [1:0] {
        MODE_RST  = 2'd0,
        MODE_INIT = 2'd1,
        MODE_CAL  = 2'd2,
        MODE_RUN  = 2'd3
    } seq_mode_t;

endpackage

// File: rtl/cal_seq_timer.sv
// Power-up settle and initial-offset timeout counter.
module cal_seq_timer #(
    parameter int PWR_CYC  = 64,
    parameter int PO_LIMIT = 115000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic pwr_done,
    output logic po_expired
);
    localparam int PW = $clog2(PO_LIMIT + 1);

    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run && cnt_q != PW'(PO_LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign pwr_done   = (cnt_q == PW'(PWR_CYC - 1));
    assign po_expired = (cnt_q == PW'(PO_LIMIT - 1));
endmodule

// File: rtl/cal_seq_edges.sv
// Counts output rising edges during calibration.
module cal_seq_edges #(
    parameter int CAL_EDGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic count_en,
    input  logic out_rise,
    output logic reached
);
    localparam int EW = $clog2(CAL_EDGES + 1);

    logic [EW-1:0] cnt_q;
    logic          full;

    assign full = (cnt_q == EW'(CAL_EDGES));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (count_en && out_rise && !full) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign reached = full || (out_rise && cnt_q == EW'(CAL_EDGES - 1));
endmodule

// File: rtl/cal_seq_gain.sv
// Saturating gain index register.
module cal_seq_gain #(
    parameter int GAIN_W    = 4,
    parameter int GAIN_INIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step_up,
    input  logic              step_dn,
    output logic [GAIN_W-1:0] gain,
    output logic              at_max,
    output logic              at_min
);
    logic [GAIN_W-1:0] gain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gain_q <= GAIN_W'(GAIN_INIT);
        end else if (load) begin
            gain_q <= GAIN_W'(GAIN_INIT);
        end else if (step_up && !at_max) begin
            gain_q <= gain_q + 1'b1;
        end else if (step_dn && !at_min) begin
            gain_q <= gain_q - 1'b1;
        end
    end

    assign gain   = gain_q;
    assign at_max = (gain_q == {GAIN_W{1'b1}});
    assign at_min = (gain_q == '0);
endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer
    import cal_seq_pkg::*;
#(
    parameter int GAIN_W    = 4,
    parameter int GAIN_INIT = 8,
    parameter int AMP_W     = 10,
    parameter int AMP_LO    = 256,
    parameter int AMP_HI    = 768,
    parameter int CAL_EDGES = 3,
    parameter int PWR_CYC   = 64,
    parameter int PO_LIMIT  = 115000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uv_flag,
    input  logic              ofs_done,
    input  logic              amp_valid,
    input  logic [AMP_W-1:0]  amp_pp,
    input  logic              out_rise,
    output logic [GAIN_W-1:0] gain_code,
    output logic              ofs_req,
    output logic              ofs_en,
    output logic              trk_en,
    output logic              out_force_hi,
    output logic [1:0]        mode,
    output logic              duty_ok
);
    seq_state_t state_q, state_d;

    logic pwr_done, po_expired, cal_reached;
    logic at_max, at_min;
    logic amp_low, amp_high, cal_decide;
    logic gain_up, gain_dn, gain_load;

    assign amp_low    = amp_valid && (amp_pp < AMP_W'(AMP_LO));
    assign amp_high   = amp_valid && (amp_pp > AMP_W'(AMP_HI));
    assign cal_decide = (state_q == ST_CAL_WAIT) && !cal_reached;
    assign gain_load  = uv_flag || (state_q == ST_RESET);
    assign gain_up    = !uv_flag && cal_decide && amp_low && !at_max;
    assign gain_dn    = !uv_flag && (cal_decide || state_q == ST_RUN)
                        && amp_high && !at_min;

    cal_seq_timer #(
        .PWR_CYC  (PWR_CYC),
        .PO_LIMIT (PO_LIMIT)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (state_q == ST_RESET),
        .run        (state_q == ST_POWERUP || state_q == ST_OFS_INIT),
        .pwr_done   (pwr_done),
        .po_expired (po_expired)
    );

    cal_seq_edges #(
        .CAL_EDGES (CAL_EDGES)
    ) u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (state_q == ST_RESET),
        .count_en (state_q == ST_CAL_WAIT || state_q == ST_CAL_RECENTER),
        .out_rise (out_rise),
        .reached  (cal_reached)
    );

    cal_seq_gain #(
        .GAIN_W    (GAIN_W),
        .GAIN_INIT (GAIN_INIT)
    ) u_gain (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (gain_load),
        .step_up (gain_up),
        .step_dn (gain_dn),
        .gain    (gain_code),
        .at_max  (at_max),
        .at_min  (at_min)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state decision
    always_comb begin
        state_d = state_q;
        if (uv_flag) begin
            state_d = ST_RESET;
        end else begin
            unique case (state_q)
                ST_RESET:        state_d = ST_POWERUP;
                ST_POWERUP:      if (pwr_done) state_d = ST_OFS_INIT;
                ST_OFS_INIT:     if (ofs_done || po_expired) state_d = ST_CAL_WAIT;
                ST_CAL_WAIT: begin
                    if (cal_reached)            state_d = ST_RUN;
                    else if (gain_up || gain_dn) state_d = ST_CAL_RECENTER;
                end
                ST_CAL_RECENTER: if (ofs_done) state_d = ST_CAL_WAIT;
                ST_RUN:          if (gain_dn) state_d = ST_RUN_RECENTER;
                ST_RUN_RECENTER: if (ofs_done) state_d = ST_RUN;
                default:         state_d = ST_RESET;
            endcase
        end
    end

    // Outputs decoded from the state
    always_comb begin
        mode         = MODE_RST;
        ofs_req      = 1'b0;
        ofs_en       = 1'b1;
        trk_en       = 1'b0;
        out_force_hi = 1'b0;
        duty_ok      = 1'b0;
        unique case (state_q)
            ST_RESET, ST_POWERUP: begin
                ofs_en       = 1'b0;
                out_force_hi = 1'b1;
            end
            ST_OFS_INIT: begin
                mode         = MODE_INIT;
                ofs_req      = 1'b1;
                out_force_hi = 1'b1;
            end
            ST_CAL_WAIT, ST_CAL_RECENTER: begin
                mode    = MODE_CAL;
                trk_en  = 1'b1;
                ofs_req = (state_q == ST_CAL_RECENTER);
            end
            ST_RUN, ST_RUN_RECENTER: begin
                mode    = MODE_RUN;
                trk_en  = 1'b1;
                duty_ok = 1'b1;
                ofs_req = (state_q == ST_RUN_RECENTER);
            end
            default: begin
                ofs_en       = 1'b0;
                out_force_hi = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/cal_seq_chk.sv
module cal_seq_chk
    import cal_seq_pkg::*;
#(
    parameter int GAIN_W    = 4,
    parameter int GAIN_INIT = 8,
    parameter int PO_LIMIT  = 115000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              uv_flag,
    input logic [GAIN_W-1:0] gain_code,
    input logic              ofs_req,
    input logic              ofs_en,
    input logic              trk_en,
    input logic              out_force_hi,
    input logic [1:0]        mode,
    input logic              duty_ok
);
    localparam int IW = $clog2(PO_LIMIT + 2);

    logic [IW-1:0] init_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_run <= '0;
        end else if (mode == MODE_INIT) begin
            if (init_run != IW'(PO_LIMIT + 1)) init_run <= init_run + 1'b1;
        end else begin
            init_run <= '0;
        end
    end

    // R1
    uv_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flag |=> (mode == MODE_RST && out_force_hi && !trk_en
                     && gain_code == GAIN_W'(GAIN_INIT)));

    // R6
    force_trk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_force_hi |-> !trk_en);

    // R8
    run_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN && $past(mode) == MODE_RUN) |-> gain_code <= $past(gain_code));

    // R5
    gain_step_recenter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_code != $past(gain_code) && mode != MODE_RST) |-> ofs_req);

    // R4
    gain_step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_code != $past(gain_code) && mode != MODE_RST)
        |-> (gain_code == $past(gain_code) + 1'b1 || gain_code == $past(gain_code) - 1'b1));

    // R9
    duty_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        duty_ok |-> mode == MODE_RUN);

    // R9
    ofs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_RST) |-> ofs_en);

    // R7
    run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN && $past(mode) != MODE_RUN) |-> $past(mode) == MODE_CAL);

    // R3
    init_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_run <= IW'(PO_LIMIT));
endmodule

bind cal_sequencer cal_seq_chk #(
    .GAIN_W    (GAIN_W),
    .GAIN_INIT (GAIN_INIT),
    .PO_LIMIT  (PO_LIMIT)
) u_cal_seq_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .uv_flag      (uv_flag),
    .gain_code    (gain_code),
    .ofs_req      (ofs_req),
    .ofs_en       (ofs_en),
    .trk_en       (trk_en),
    .out_force_hi (out_force_hi),
    .mode         (mode),
    .duty_ok      (duty_ok)
);

// File: tb/cal_sequencer_bench.sv
module cal_sequencer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       uv_flag = 1'b1;
    logic       ofs_done = 1'b0;
    logic       amp_valid = 1'b0;
    logic [7:0] amp_pp = 8'd0;
    logic       out_rise = 1'b0;
    logic [2:0] gain_code;
    logic       ofs_req, ofs_en, trk_en, out_force_hi, duty_ok;
    logic [1:0] mode;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [1:0] m;
        logic       fh;
        logic       trk;
        logic       oe;
        logic       oreq;
        logic       duty;
        logic [2:0] g;
        string      req;
    } exp_t;

    exp_t exp_q[$];

    always #10 clk = ~clk;

    cal_sequencer #(
        .GAIN_W    (3),
        .GAIN_INIT (4),
        .AMP_W     (8),
        .AMP_LO    (64),
        .AMP_HI    (192),
        .CAL_EDGES (3),
        .PWR_CYC   (3),
        .PO_LIMIT  (20)
    ) u_cal_sequencer (
        .clk          (clk),
        .rst_n        (rst_n),
        .uv_flag      (uv_flag),
        .ofs_done     (ofs_done),
        .amp_valid    (amp_valid),
        .amp_pp       (amp_pp),
        .out_rise     (out_rise),
        .gain_code    (gain_code),
        .ofs_req      (ofs_req),
        .ofs_en       (ofs_en),
        .trk_en       (trk_en),
        .out_force_hi (out_force_hi),
        .mode         (mode),
        .duty_ok      (duty_ok)
    );

    // Driver: one edge, then queue what the outputs must be after it.
    task automatic tick_exp(input logic [1:0] m, input logic fh, input logic trk,
                            input logic oe, input logic oreq, input logic duty,
                            input logic [2:0] g, input string req);
        exp_t e;
        e.m = m; e.fh = fh; e.trk = trk; e.oe = oe;
        e.oreq = oreq; e.duty = duty; e.g = g; e.req = req;
        @(posedge clk);
        #1;
        exp_q.push_back(e);
        amp_valid = 1'b0;
        out_rise  = 1'b0;
        ofs_done  = 1'b0;
    endtask

    task automatic t_rst(input logic [2:0] g, input string req);
        tick_exp(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, g, req);
    endtask
    task automatic t_init(input logic [2:0] g, input string req);
        tick_exp(2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, g, req);
    endtask
    task automatic t_cal(input logic oreq, input logic [2:0] g, input string req);
        tick_exp(2'd2, 1'b0, 1'b1, 1'b1, oreq, 1'b0, g, req);
    endtask
    task automatic t_run(input logic oreq, input logic [2:0] g, input string req);
        tick_exp(2'd3, 1'b0, 1'b1, 1'b1, oreq, 1'b1, g, req);
    endtask

    task automatic amp(input logic [7:0] a);
        amp_valid = 1'b1;
        amp_pp    = a;
    endtask

    // Monitor: compares away from the active edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if ({mode, out_force_hi, trk_en, ofs_en, ofs_req, duty_ok, gain_code} !==
                {e.m, e.fh, e.trk, e.oe, e.oreq, e.duty, e.g}) begin
                errors++;
                $display("FAIL %s: got mode=%0d fh=%0b trk=%0b oe=%0b req=%0b duty=%0b gain=%0d exp mode=%0d fh=%0b trk=%0b oe=%0b req=%0b duty=%0b gain=%0d",
                         e.req, mode, out_force_hi, trk_en, ofs_en, ofs_req, duty_ok, gain_code,
                         e.m, e.fh, e.trk, e.oe, e.oreq, e.duty, e.g);
            end
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: reset state, held while undervoltage persists
        repeat (4) t_rst(3'd4, "R1");

        // R2: power-up settle then initial offset with output held high
        uv_flag = 1'b0;
        repeat (3) t_rst(3'd4, "R2");
        repeat (4) t_init(3'd4, "R2");
        ofs_done = 1'b1;
        t_cal(1'b0, 3'd4, "R2 R6");

        // R4 R5: low amplitude raises gain, amplitude ignored while recentering
        amp(8'd30);  t_cal(1'b1, 3'd5, "R4 R5");
        amp(8'd30);  t_cal(1'b1, 3'd5, "R5 ignored");
        ofs_done = 1'b1; t_cal(1'b0, 3'd5, "R5");
        amp(8'd250); t_cal(1'b1, 3'd4, "R4 high");
        ofs_done = 1'b1; t_cal(1'b0, 3'd4, "R5");
        amp(8'd100); t_cal(1'b0, 3'd4, "R4 window");
        amp(8'd64);  t_cal(1'b0, 3'd4, "R4 lo bound");
        amp(8'd192); t_cal(1'b0, 3'd4, "R4 hi bound");
        for (int g = 5; g <= 7; g++) begin
            amp(8'd10); t_cal(1'b1, 3'(g), "R4");
            ofs_done = 1'b1; t_cal(1'b0, 3'(g), "R5");
        end
        // R10: saturation at the top
        amp(8'd10);  t_cal(1'b0, 3'd7, "R10 max");

        // R6 R7: edges during calibration, third one enters running
        out_rise = 1'b1; t_cal(1'b0, 3'd7, "R6");
        out_rise = 1'b1; t_cal(1'b0, 3'd7, "R7");
        out_rise = 1'b1; amp(8'd250); t_run(1'b0, 3'd7, "R7 R9");

        // R8: running gain only decreases
        amp(8'd10);  t_run(1'b0, 3'd7, "R8 no raise");
        amp(8'd250); t_run(1'b1, 3'd6, "R8");
        amp(8'd250); t_run(1'b1, 3'd6, "R5 run ignored");
        ofs_done = 1'b1; t_run(1'b0, 3'd6, "R8");
        for (int g = 6; g > 0; g--) begin
            amp(8'd250); t_run(1'b1, 3'(g - 1), "R8");
            ofs_done = 1'b1; t_run(1'b0, 3'(g - 1), "R8");
        end
        // R10: saturation at the bottom
        amp(8'd250); t_run(1'b0, 3'd0, "R10 min");

        // R11: undervoltage from running restarts everything
        uv_flag = 1'b1;
        t_rst(3'd4, "R11 R1");
        t_rst(3'd4, "R11");
        uv_flag = 1'b0;
        // R3: no offset settle, timeout releases on edge PO_LIMIT after power-up start
        repeat (3)  t_rst(3'd4, "R3");
        repeat (17) t_init(3'd4, "R3");
        t_cal(1'b0, 3'd4, "R3 timeout");
        // R11: edge count restarted
        out_rise = 1'b1; t_cal(1'b0, 3'd4, "R11 edges");
        out_rise = 1'b1; t_cal(1'b0, 3'd4, "R11 edges");
        out_rise = 1'b1; t_run(1'b0, 3'd4, "R11 R7");

        @(negedge clk);
        #1;
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got running exp finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule